// File: doc/BRIEF.md
# Integration Period and Count Controller

This block times the integration windows of a two-channel light counter and turns the pulse streams from both channels into 16-bit results. An oscillator tick paces all timing. A two-bit period field picks one of three fixed window lengths, each a whole multiple of a base of 918 ticks. The fourth field value hands the start and stop of the window to a manual bit. Inside a window, each channel accepts at most one count per two ticks. When the window closes, both results are written to their output registers on the same edge, and a one-cycle done strobe fires on that edge. In the fixed modes the next window then starts with no outside action.

Each published result is the number of accepted counts minus two, held at zero from below and clipped at the largest result value. With a steady pulse input, the full-scale values are therefore 5047 for the shortest setting and 37177 for the middle setting, and the longest setting hits the 16-bit ceiling. A gain input plays no part in counting. The block stores it with each result so that software knows which gain the result was taken under. The base length and the result width are parameters, so that a scaled-down copy can be checked in full.

Top module: `light_integ_ctrl`

## Requirements
- R1: After reset both results read 0, the stored gain reads 0 and done is low.
- R2: The block integrates only while the power field equals 2'b11. With any other power value no count is taken and done stays low.
- R3: In period field 2'b00 a window lasts 11·UNIT ticks, in 2'b01 it lasts 81·UNIT ticks, and in 2'b10 it lasts 322·UNIT ticks. Done rises on the edge that takes the last tick of the window.
- R4: In the fixed modes a new window starts on the tick after a transfer, with no idle tick between the two windows.
- R5: A channel pulse is sampled only on a tick. It is accepted only if that channel accepted nothing on the previous tick, and a pulse that breaks this rule is dropped.
- R6: A published result is the accepted count minus 2, floored at 0 and clipped at 2^DW−1.
- R7: Both results update on the same edge as done. At all other times they hold their value.
- R8: In field 2'b11, raising the manual bit starts a window from zero. Clearing it transfers the counts taken so far on the next edge. While the bit stays low, nothing happens.
- R9: In the fixed fields the manual bit has no effect on window timing or results.
- R10: A change of the period field during a window drops that window without a transfer and starts a fresh window of the new length.
- R11: Done is high for exactly one clock cycle per transfer.
- R12: The gain input is captured into the stored gain bit on each transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| osc_tick | input | 1 | Oscillator period enable |
| pwr | input | 2 | Power field; 2'b11 runs the block |
| period | input | 2 | Window length select; 2'b11 selects manual mode |
| manual | input | 1 | Manual start (1) and stop (0) in period 2'b11 |
| gain | input | 1 | Gain setting recorded with each result |
| ch0_pulse | input | 1 | Count pulse of channel 0 |
| ch1_pulse | input | 1 | Count pulse of channel 1 |
| data0 | output | DW | Published result of channel 0 |
| data1 | output | DW | Published result of channel 1 |
| gain_tag | output | 1 | Gain in force at the last transfer |
| done | output | 1 | One-cycle strobe on each transfer |

## Verification
A wrong window counter shows up at the ports as a done strobe on the wrong tick, and the bench sees it as soon as the first window ends, before the result value is even compared. A fault in the gap flag or the offset changes both results by a fixed amount, which a sweep over pulse spacings exposes on every window. State left over after an abort or a manual stop shows in the first result published afterwards. A done that lasts too long appears in the cycle that follows the transfer.

// File: rtl/light_integ_ctrl.sv
module light_integ_ctrl #(
  parameter int UNIT = 918,
  parameter int DW   = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          osc_tick,
  input  logic [1:0]    pwr,
  input  logic [1:0]    period,
  input  logic          manual,
  input  logic          gain,
  input  logic          ch0_pulse,
  input  logic          ch1_pulse,
  output logic [DW-1:0] data0,
  output logic [DW-1:0] data1,
  output logic          gain_tag,
  output logic          done
);
  localparam int LMAX = 322 * UNIT;
  localparam int CW   = $clog2(LMAX);
  localparam int AW   = DW + 1;
  localparam logic [AW-1:0] TOP = AW'((2 ** DW) + 1);

  logic [CW-1:0] cnt;
  logic [AW-1:0] acc0, acc1;
  logic          blk0, blk1, run;
  logic [1:0]    per_q;

  function automatic logic [CW-1:0] last_of(input logic [1:0] f);
    case (f)
      2'b00:   last_of = CW'(11 * UNIT - 1);
      2'b01:   last_of = CW'(81 * UNIT - 1);
      default: last_of = CW'(322 * UNIT - 1);
    endcase
  endfunction

  function automatic logic [DW-1:0] fin(input logic [AW-1:0] a);
    fin = (a < AW'(2)) ? '0 : DW'(a - AW'(2));
  endfunction

  wire pon   = (pwr == 2'b11);
  wire fixed = (period != 2'b11);
  wire want  = pon && (fixed || manual);
  wire chg   = (period != per_q);
  wire a0    = osc_tick && ch0_pulse && !blk0;
  wire a1    = osc_tick && ch1_pulse && !blk1;
  wire [AW-1:0] nx0 = (acc0 == TOP) ? acc0 : acc0 + AW'(a0);
  wire [AW-1:0] nx1 = (acc1 == TOP) ? acc1 : acc1 + AW'(a1);
  wire wend  = fixed && osc_tick && (cnt == last_of(period));

  always_ff @(posedge clk) begin
    if (rst) begin
      data0 <= '0; data1 <= '0; gain_tag <= 1'b0; done <= 1'b0;
      cnt <= '0; acc0 <= '0; acc1 <= '0; blk0 <= 1'b0; blk1 <= 1'b0;
      run <= 1'b0; per_q <= 2'b00;
    end else begin
      done  <= 1'b0;
      per_q <= period;
      if (!want || chg) begin
        if (run && pon && !chg && !fixed) begin
          data0 <= fin(acc0); data1 <= fin(acc1);
          gain_tag <= gain; done <= 1'b1;
        end
        run <= 1'b0; cnt <= '0;
        acc0 <= '0; acc1 <= '0; blk0 <= 1'b0; blk1 <= 1'b0;
      end else begin
        run <= 1'b1;
        if (wend) begin
          data0 <= fin(nx0); data1 <= fin(nx1);
          gain_tag <= gain; done <= 1'b1;
          cnt <= '0; acc0 <= '0; acc1 <= '0; blk0 <= 1'b0; blk1 <= 1'b0;
        end else if (osc_tick) begin
          if (fixed) cnt <= cnt + CW'(1);
          acc0 <= nx0; acc1 <= nx1;
          blk0 <= a0;  blk1 <= a1;
        end
      end
    end
  end

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(data0) && $stable(data1)));
  // R11
  one_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R2
  power_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(pwr) == 2'b11);
  // R3
  fixed_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (done && $past(period) != 2'b11) |-> $past(osc_tick));
endmodule

// File: tb/light_integ_ctrl_test.sv
module light_integ_ctrl_test;
  localparam int UNIT = 8;
  localparam int DW   = 10;
  localparam int MAXV = (2 ** DW) - 1;
  localparam int L0 = 11 * UNIT, L1 = 81 * UNIT, L2 = 322 * UNIT;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic osc_tick = 1'b0, manual = 1'b0, gain = 1'b0, ch0_pulse = 1'b0, ch1_pulse = 1'b0;
  logic [1:0] pwr = 2'b00, period = 2'b00;
  logic [DW-1:0] data0, data1;
  logic gain_tag, done;

  int total = 0, bad = 0;
  int first_done, last_done, ndone, v0, v1, w0, w1, g;

  always #10 clk = ~clk;

  light_integ_ctrl #(.UNIT(UNIT), .DW(DW)) uut (
    .clk(clk), .rst(rst), .osc_tick(osc_tick), .pwr(pwr), .period(period),
    .manual(manual), .gain(gain), .ch0_pulse(ch0_pulse), .ch1_pulse(ch1_pulse),
    .data0(data0), .data1(data1), .gain_tag(gain_tag), .done(done));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expv(input int len, input int p);
    int a;
    if (p == 0) a = 0;
    else if (p == 1) a = len / 2;
    else a = (len + p - 1) / p;
    a = a - 2;
    if (a < 0) a = 0;
    if (a > MAXV) a = MAXV;
    return a;
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic win(input int n, input int p0, input int p1, input int gapc);
    first_done = -1; last_done = -1; ndone = 0;
    for (int k = 0; k < n; k++) begin
      osc_tick  = 1'b1;
      ch0_pulse = (p0 > 0) && (k % p0 == 0);
      ch1_pulse = (p1 > 0) && (k % p1 == 0);
      @(posedge clk); @(negedge clk);
      osc_tick = 1'b0; ch0_pulse = 1'b0; ch1_pulse = 1'b0;
      if (done) begin
        ndone++;
        if (first_done < 0) begin
          first_done = k; v0 = data0; v1 = data1; g = gain_tag;
        end
        last_done = k; w0 = data0; w1 = data1;
      end
      for (int j = 0; j < gapc; j++) begin
        @(posedge clk); @(negedge clk);
        if (done) ndone++;
      end
    end
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(data0 == 0 && data1 == 0, "R1 data", data0 + data1, 0);
    chk(!done && !gain_tag, "R1 flags", done + gain_tag, 0);

    // R2: power field not 2'b11
    pwr = 2'b01; idle(2);
    win(300, 1, 1, 0);
    chk(ndone == 0, "R2 no done", ndone, 0);
    chk(data0 == 0, "R2 data0", data0, 0);

    // R3 R4 R6: shortest window, dark channel 1
    pwr = 2'b11; period = 2'b00; idle(2);
    win(2 * L0, 1, 0, 0);
    chk(first_done == L0 - 1, "R3 len 00", first_done, L0 - 1);
    chk(v0 == expv(L0, 1), "R6 full 00", v0, expv(L0, 1));
    chk(v1 == 0, "R6 floor", v1, 0);
    chk(last_done == 2 * L0 - 1 && ndone == 2, "R4 restart", last_done, 2 * L0 - 1);
    chk(w0 == expv(L0, 1), "R4 second", w0, expv(L0, 1));

    // R5 R6: sweep of pulse spacing on both channels
    for (int p = 1; p <= 6; p++) begin
      win(L0, p, 7 - p, 0);
      chk(first_done == L0 - 1, "R3 sweep len", first_done, L0 - 1);
      chk(v0 == expv(L0, p), "R5 ch0 spacing", v0, expv(L0, p));
      chk(v1 == expv(L0, 7 - p), "R5 ch1 spacing", v1, expv(L0, 7 - p));
    end

    // R5: idle clocks between ticks do not count
    win(L0, 1, 2, 2);
    chk(v0 == expv(L0, 1) && v1 == expv(L0, 2), "R5 sparse ticks", v0, expv(L0, 1));

    // R12
    gain = 1'b1;
    win(L0, 3, 0, 0);
    chk(g == 1, "R12 gain", g, 1);
    gain = 1'b0;

    // R3: middle window
    period = 2'b01; idle(2);
    win(L1, 1, 3, 0);
    chk(first_done == L1 - 1, "R3 len 01", first_done, L1 - 1);
    chk(v0 == expv(L1, 1) && v1 == expv(L1, 3), "R6 01", v0, expv(L1, 1));

    // R3 R6: longest window clips
    period = 2'b10; idle(2);
    win(L2, 1, 4, 0);
    chk(first_done == L2 - 1, "R3 len 10", first_done, L2 - 1);
    chk(v0 == MAXV, "R6 clip", v0, MAXV);
    chk(v1 == expv(L2, 4), "R6 10 ch1", v1, expv(L2, 4));

    // R10: field change mid-window
    period = 2'b00; idle(2);
    win(40, 1, 1, 0);
    chk(ndone == 0, "R10 partial", ndone, 0);
    period = 2'b01; idle(1);
    win(L1, 1, 0, 0);
    chk(first_done == L1 - 1, "R10 new length", first_done, L1 - 1);
    chk(v0 == expv(L1, 1), "R10 fresh count", v0, expv(L1, 1));

    // R8: manual mode
    period = 2'b11; manual = 1'b0; idle(2);
    win(100, 1, 1, 0);
    chk(ndone == 0, "R8 low idle", ndone, 0);
    manual = 1'b1; idle(1);
    win(50, 2, 5, 0);
    chk(ndone == 0, "R8 running", ndone, 0);
    manual = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(done == 1, "R8 stop done", done, 1);
    chk(data0 == expv(50, 2) && data1 == expv(50, 5), "R8 value", data0, expv(50, 2));
    @(posedge clk); @(negedge clk);
    // R11
    chk(done == 0, "R11 width", done, 0);
    idle(20);
    // R7
    chk(data0 == expv(50, 2), "R7 hold", data0, expv(50, 2));

    // R9: manual bit ignored in fixed field
    period = 2'b00; manual = 1'b1; idle(2);
    win(L0 / 2, 1, 0, 0);
    chk(ndone == 0, "R9 early", ndone, 0);
    manual = 1'b0;
    win(L0 / 2, 1, 0, 0);
    chk(first_done == L0 / 2 - 1, "R9 timing", first_done, L0 / 2 - 1);
    chk(v0 == expv(L0, 1), "R9 value", v0, expv(L0, 1));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule